// File: doc/BRIEF.md
# Register-Driven Parallel Flash Byte Access Engine

This block lets software reach an external byte-wide parallel flash one byte at a time through two registers on a small register bus. The command register carries a 19-bit byte address, a direction bit and a combined start/busy bit. The data register carries the byte: software loads it before a write, and it holds the fetched byte after a read completes. Software sets the start bit and then polls it. The engine holds the bit high for the whole access and clears it only when the flash cycle has finished.

The flash may also be reached through a memory-mapped window elsewhere in the chip. Sharing the pins with that path is reduced to a request/grant pair. The engine raises its request while an access is pending and does not touch the flash until the grant is high. Each access is a single read strobe or a single write pulse. Program and erase command algorithms are left to software.

Top module: `flash_reg_engine`

## Requirements
- R1: The command register sits at byte offset 0x50, with the address in bits [18:0], the direction in bit 24 (1 = read, 0 = write) and start/busy in bit 25. The data register sits at 0x54 with the byte in bits [7:0]. Every other bit, and every other offset, reads zero, and writes to other offsets change nothing. Reset clears every field.
- R2: A write to the command register while idle loads the address and direction, and it loads bit 25 from the written value. If bit 25 becomes 1, it reads 1 until the flash cycle ends and then reads 0. Writing 0 to bit 25 starts nothing.
- R3: `fl_req` equals the busy bit. No flash cycle begins while `fl_gnt` is low. A cycle starts on the clock after a clock edge at which the engine is busy and `fl_gnt` is high.
- R4: A read holds `fl_cs_n` and `fl_rd_n` low for exactly RD_CYC clocks with the address on `fl_addr`. The byte on `fl_dq_in` in the last of those clocks is stored in the data register. The busy bit clears on that same edge.
- R5: A write drives the data byte with `fl_dq_oe` high and holds `fl_cs_n` and `fl_wr_n` low for exactly WE_CYC clocks. It then holds `fl_wr_n` high for HOLD_CYC clocks (at least 1), with chip select, address and data unchanged, before busy clears.
- R6: While busy, writes to the command register and to the data register are ignored entirely, including another start request.
- R7: `fl_rd_n` and `fl_wr_n` are never low together. While not busy, `fl_cs_n` is high, `fl_dq_oe` is low and `fl_addr` is parked at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 8 | Register byte offset |
| reg_wen | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| fl_req | output | 1 | Pin-sharing request, high while busy |
| fl_gnt | input | 1 | Pin-sharing grant |
| fl_addr | output | 19 | Flash byte address |
| fl_cs_n | output | 1 | Flash chip select, active low |
| fl_rd_n | output | 1 | Flash output enable, active low |
| fl_wr_n | output | 1 | Flash write strobe, active low |
| fl_dq_out | output | 8 | Data driven toward the flash |
| fl_dq_oe | output | 1 | Drive enable for `fl_dq_out` |
| fl_dq_in | input | 8 | Data returned from the flash |

## Verification
The bench writes to both registers while an access is pending. A design that let these writes through would change the address on the pins in the middle of a cycle, start a second access, or overwrite the byte to be written, and the later read-back and flash-model contents expose each of these. It holds the grant low and checks that the pins stay idle, since an engine that ignored the grant would fight the window path. Pin monitors measure the exact strobe widths, the data hold after the write strobe rises, and the point at which busy clears, so an off-by-one counter or capture on the wrong clock shows up as a wrong width or a stale byte. Writes with bit 25 clear and with all-ones values check that nothing starts and that unused bits stay zero.

// File: rtl/flashx_pkg.sv
package flashx_pkg;

   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,
      PH_READ   = 2'd1,
      PH_WPULSE = 2'd2,
      PH_WHOLD  = 2'd3
   } phase_t;

   function automatic int unsigned max3(input int unsigned a,
                                        input int unsigned b,
                                        input int unsigned c);
      int unsigned m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      return m;
   endfunction

endpackage

// File: rtl/flashx_regs.sv
module flashx_regs #(
   parameter int unsigned REG_AW   = 8,
   parameter int unsigned REG_DW   = 32,
   parameter int unsigned ADDR_W   = 19,
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned CMD_OFS  = 'h50,
   parameter int unsigned DATA_OFS = 'h54,
   parameter int unsigned DIR_BIT  = 24,
   parameter int unsigned GO_BIT   = 25
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic              reg_wen,
   input  logic [REG_DW-1:0] reg_wdata,
   output logic [REG_DW-1:0] reg_rdata,
   input  logic              done,
   input  logic [DATA_W-1:0] cap_data,
   output logic              busy,
   output logic              is_read,
   output logic [ADDR_W-1:0] addr,
   output logic [DATA_W-1:0] data
);

   localparam logic [REG_AW-1:0] CMD_SEL  = REG_AW'(CMD_OFS);
   localparam logic [REG_AW-1:0] DATA_SEL = REG_AW'(DATA_OFS);

   logic hit_cmd;
   logic hit_data;
   logic unused_wbits;

   assign hit_cmd      = reg_wen && (reg_addr == CMD_SEL);
   assign hit_data     = reg_wen && (reg_addr == DATA_SEL);
   assign unused_wbits = ^reg_wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         is_read <= 1'b0;
         addr    <= '0;
         data    <= '0;
      end else if (done) begin
         busy <= 1'b0;
         if (is_read) data <= cap_data;
      end else if (!busy) begin
         if (hit_cmd) begin
            addr    <= reg_wdata[ADDR_W-1:0];
            is_read <= reg_wdata[DIR_BIT];
            busy    <= reg_wdata[GO_BIT];
         end
         if (hit_data) data <= reg_wdata[DATA_W-1:0];
      end
   end

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == CMD_SEL) begin
         reg_rdata[ADDR_W-1:0] = addr;
         reg_rdata[DIR_BIT]    = is_read;
         reg_rdata[GO_BIT]     = busy;
      end else if (reg_addr == DATA_SEL) begin
         reg_rdata[DATA_W-1:0] = data;
      end
   end

endmodule

// File: rtl/flashx_seq.sv
module flashx_seq
   import flashx_pkg::*;
#(
   parameter int unsigned RD_CYC   = 3,
   parameter int unsigned WE_CYC   = 2,
   parameter int unsigned HOLD_CYC = 1
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   busy,
   input  logic   is_read,
   input  logic   gnt,
   output phase_t phase,
   output logic   done
);

   localparam int unsigned MAXC  = max3(RD_CYC, WE_CYC, HOLD_CYC);
   localparam int unsigned CNT_W = (MAXC < 2) ? 1 : $clog2(MAXC);
   localparam logic [CNT_W-1:0] RD_LAST   = CNT_W'(RD_CYC - 1);
   localparam logic [CNT_W-1:0] WE_LAST   = CNT_W'(WE_CYC - 1);
   localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(HOLD_CYC - 1);

   phase_t           ph_q, ph_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;

   always_comb begin
      ph_d  = ph_q;
      cnt_d = cnt_q + CNT_W'(1);
      done  = 1'b0;
      unique case (ph_q)
         PH_IDLE: begin
            cnt_d = '0;
            if (busy && gnt) ph_d = is_read ? PH_READ : PH_WPULSE;
         end
         PH_READ: begin
            if (cnt_q == RD_LAST) begin
               ph_d  = PH_IDLE;
               cnt_d = '0;
               done  = 1'b1;
            end
         end
         PH_WPULSE: begin
            if (cnt_q == WE_LAST) begin
               ph_d  = PH_WHOLD;
               cnt_d = '0;
            end
         end
         PH_WHOLD: begin
            if (cnt_q == HOLD_LAST) begin
               ph_d  = PH_IDLE;
               cnt_d = '0;
               done  = 1'b1;
            end
         end
         default: begin
            ph_d  = PH_IDLE;
            cnt_d = '0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q  <= PH_IDLE;
         cnt_q <= '0;
      end else begin
         ph_q  <= ph_d;
         cnt_q <= cnt_d;
      end
   end

   assign phase = ph_q;

endmodule

// File: rtl/flashx_pins.sv
module flashx_pins
   import flashx_pkg::*;
#(
   parameter int unsigned ADDR_W    = 19,
   parameter int unsigned DATA_W    = 8,
   parameter bit          PARK_ADDR = 1'b1
) (
   input  phase_t            phase,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [ADDR_W-1:0] fl_addr,
   output logic              fl_cs_n,
   output logic              fl_rd_n,
   output logic              fl_wr_n,
   output logic [DATA_W-1:0] fl_dq_out,
   output logic              fl_dq_oe
);

   logic active;
   logic writing;

   assign active    = (phase != PH_IDLE);
   assign writing   = (phase == PH_WPULSE) || (phase == PH_WHOLD);
   assign fl_cs_n   = !active;
   assign fl_rd_n   = !(phase == PH_READ);
   assign fl_wr_n   = !(phase == PH_WPULSE);
   assign fl_dq_oe  = writing;
   assign fl_dq_out = writing ? wdata : '0;

   generate
      if (PARK_ADDR) begin : g_park
         assign fl_addr = active ? addr : '0;
      end else begin : g_hold
         assign fl_addr = addr;
      end
   endgenerate

endmodule

// File: rtl/flash_reg_engine.sv
module flash_reg_engine
   import flashx_pkg::*;
#(
   parameter int unsigned REG_AW    = 8,
   parameter int unsigned REG_DW    = 32,
   parameter int unsigned ADDR_W    = 19,
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned CMD_OFS   = 'h50,
   parameter int unsigned DATA_OFS  = 'h54,
   parameter int unsigned DIR_BIT   = 24,
   parameter int unsigned GO_BIT    = 25,
   parameter int unsigned RD_CYC    = 3,
   parameter int unsigned WE_CYC    = 2,
   parameter int unsigned HOLD_CYC  = 1,
   parameter bit          PARK_ADDR = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic              reg_wen,
   input  logic [REG_DW-1:0] reg_wdata,
   output logic [REG_DW-1:0] reg_rdata,
   output logic              fl_req,
   input  logic              fl_gnt,
   output logic [ADDR_W-1:0] fl_addr,
   output logic              fl_cs_n,
   output logic              fl_rd_n,
   output logic              fl_wr_n,
   output logic [DATA_W-1:0] fl_dq_out,
   output logic              fl_dq_oe,
   input  logic [DATA_W-1:0] fl_dq_in
);

   generate
      if (ADDR_W == 0 || ADDR_W > DIR_BIT) begin : g_bad_addr
         $error("flash_reg_engine: ADDR_W must be 1..DIR_BIT");
      end
      if (DIR_BIT == GO_BIT || GO_BIT >= REG_DW || DIR_BIT >= REG_DW) begin : g_bad_bits
         $error("flash_reg_engine: control bits overlap or exceed REG_DW");
      end
      if (DATA_W == 0 || DATA_W > REG_DW) begin : g_bad_data
         $error("flash_reg_engine: DATA_W out of range");
      end
      if (RD_CYC < 1 || WE_CYC < 1 || HOLD_CYC < 1) begin : g_bad_timing
         $error("flash_reg_engine: cycle counts must be at least 1");
      end
      if (CMD_OFS == DATA_OFS || CMD_OFS >= (1 << REG_AW) || DATA_OFS >= (1 << REG_AW)) begin : g_bad_ofs
         $error("flash_reg_engine: register offsets invalid");
      end
   endgenerate

   logic              busy_w;
   logic              isrd_w;
   logic [ADDR_W-1:0] addr_w;
   logic [DATA_W-1:0] data_w;
   logic              done_w;
   phase_t            phase_w;

   flashx_regs #(
      .REG_AW(REG_AW), .REG_DW(REG_DW), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
      .CMD_OFS(CMD_OFS), .DATA_OFS(DATA_OFS), .DIR_BIT(DIR_BIT), .GO_BIT(GO_BIT)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .reg_addr(reg_addr), .reg_wen(reg_wen), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata),
      .done(done_w), .cap_data(fl_dq_in),
      .busy(busy_w), .is_read(isrd_w), .addr(addr_w), .data(data_w)
   );

   flashx_seq #(
      .RD_CYC(RD_CYC), .WE_CYC(WE_CYC), .HOLD_CYC(HOLD_CYC)
   ) u_seq (
      .clk(clk), .rst_n(rst_n),
      .busy(busy_w), .is_read(isrd_w), .gnt(fl_gnt),
      .phase(phase_w), .done(done_w)
   );

   flashx_pins #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PARK_ADDR(PARK_ADDR)
   ) u_pins (
      .phase(phase_w), .addr(addr_w), .wdata(data_w),
      .fl_addr(fl_addr), .fl_cs_n(fl_cs_n), .fl_rd_n(fl_rd_n),
      .fl_wr_n(fl_wr_n), .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe)
   );

   assign fl_req = busy_w;

endmodule

// File: rtl/flashx_chk.sv
module flashx_chk #(
   parameter int unsigned ADDR_W = 19,
   parameter int unsigned DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              gnt,
   input logic [ADDR_W-1:0] addr_q,
   input logic              cs_n,
   input logic              rd_n,
   input logic              wr_n,
   input logic              dq_oe,
   input logic [DATA_W-1:0] dq_out
);

   a_r3_start_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cs_n) |-> $past(gnt));

   a_r7_no_strobe_overlap: assert property (@(posedge clk) disable iff (!rst_n)
      !(!rd_n && !wr_n));

   a_r7_select_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_n |-> busy);

   a_r5_data_held_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wr_n) |-> (!cs_n && dq_oe && $stable(dq_out)));

   a_r6_addr_frozen_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(addr_q));

   a_r2_busy_clears_after_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(!cs_n));

endmodule

bind flash_reg_engine flashx_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy_w), .gnt(fl_gnt), .addr_q(addr_w),
   .cs_n(fl_cs_n), .rd_n(fl_rd_n), .wr_n(fl_wr_n),
   .dq_oe(fl_dq_oe), .dq_out(fl_dq_out)
);

// File: tb/test_flash_reg_engine.sv
`timescale 1ns/1ps
module test_flash_reg_engine;

   localparam int RD_CYC   = 3;
   localparam int WE_CYC   = 2;
   localparam int HOLD_CYC = 1;
   localparam logic [7:0] CMD  = 8'h50;
   localparam logic [7:0] DATR = 8'h54;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic        reg_wen = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        fl_req;
   logic        fl_gnt = 1'b1;
   logic [18:0] fl_addr;
   logic        fl_cs_n, fl_rd_n, fl_wr_n, fl_dq_oe;
   logic [7:0]  fl_dq_out;
   logic [7:0]  fl_dq_in = 8'hEE;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   bit rand_gnt = 1'b0;

   logic [7:0] fmem    [int];
   logic [7:0] exp_mem [int];

   always #2 clk = ~clk;

   flash_reg_engine #(.RD_CYC(RD_CYC), .WE_CYC(WE_CYC), .HOLD_CYC(HOLD_CYC)) i_flash_reg_engine (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wen(reg_wen),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fl_req(fl_req), .fl_gnt(fl_gnt),
      .fl_addr(fl_addr), .fl_cs_n(fl_cs_n), .fl_rd_n(fl_rd_n), .fl_wr_n(fl_wr_n),
      .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe), .fl_dq_in(fl_dq_in)
   );

   function automatic logic [7:0] init_pat(input int a);
      return 8'(a) ^ 8'(a >> 8) ^ 8'h5A;
   endfunction

   function automatic logic [7:0] expect_byte(input int a);
      return exp_mem.exists(a) ? exp_mem[a] : init_pat(a);
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", checks - fails, checks);
   endtask

   // flash model and pin monitors, all on the falling edge
   int         rd_low = 0;
   int         wr_low = 0;
   logic       wr_prev = 1'b1;
   logic       cs_prev = 1'b1;
   logic       rd_prev = 1'b1;
   logic [7:0] dq_prev = '0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (!fl_rd_n && !fl_wr_n)
            chk(1'b0, "R7", "read and write strobes overlap", 32'd1, 32'd0);
         if (!fl_req)
            chk(fl_cs_n && !fl_dq_oe && fl_addr == '0, "R7", "idle pins",
                {fl_cs_n, fl_dq_oe, 11'd0, fl_addr}, {1'b1, 1'b0, 30'd0});
         if (!fl_rd_n) rd_low++;
         else if (!rd_prev) begin
            chk(rd_low == RD_CYC, "R4", "read strobe width", rd_low, RD_CYC);
            chk(!fl_req, "R4", "busy clear right after read strobe", fl_req, 0);
            rd_low = 0;
         end
         if (!fl_wr_n) wr_low++;
         else if (!wr_prev) begin
            chk(wr_low == WE_CYC, "R5", "write strobe width", wr_low, WE_CYC);
            chk(!fl_cs_n && fl_dq_oe && fl_dq_out == dq_prev, "R5",
                "data held after write strobe", {fl_cs_n, fl_dq_oe, fl_dq_out}, {2'b01, dq_prev});
            fmem[int'(fl_addr)] = dq_prev;
            wr_low = 0;
         end
         if (fl_cs_n && !cs_prev)
            chk(!fl_req, "R5", "busy clear when select rises", fl_req, 0);
      end
      wr_prev = fl_wr_n;
      cs_prev = fl_cs_n;
      rd_prev = fl_rd_n;
      dq_prev = fl_dq_out;
      if (!fl_cs_n && !fl_rd_n)
         fl_dq_in = fmem.exists(int'(fl_addr)) ? fmem[int'(fl_addr)] : init_pat(int'(fl_addr));
      else
         fl_dq_in = 8'hEE;
      if (rand_gnt) fl_gnt = ($urandom % 3) != 0;
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc == 150000) begin
         chk(1'b0, "R2", "watchdog expired", cyc, 0);
         summary();
         $finish;
      end
   end

   task automatic reg_wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wen = 1'b1;
      @(negedge clk);
      reg_wen = 1'b0;
   endtask

   task automatic reg_rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic wait_idle();
      logic [31:0] v;
      for (int k = 0; k < 400; k++) begin
         reg_rd(CMD, v);
         if (!v[25]) return;
      end
      chk(1'b0, "R2", "busy never cleared", 1, 0);
   endtask

   task automatic do_write(input int a, input logic [7:0] d);
      reg_wr(DATR, {24'd0, d});
      reg_wr(CMD, 32'h0200_0000 | a);
      wait_idle();
      exp_mem[a] = d;
   endtask

   task automatic do_read(input int a, output logic [7:0] d);
      logic [31:0] v;
      reg_wr(CMD, 32'h0300_0000 | a);
      wait_idle();
      reg_rd(DATR, v);
      d = v[7:0];
   endtask

   initial begin
      logic [31:0] v;
      logic [7:0]  b;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      // R1 R7: reset state
      reg_rd(CMD, v);  chk(v == 0, "R1", "command register after reset", v, 0);
      reg_rd(DATR, v); chk(v == 0, "R1", "data register after reset", v, 0);
      chk(fl_cs_n && fl_rd_n && fl_wr_n && !fl_dq_oe && fl_addr == 0 && !fl_req,
          "R7", "pins during reset", {fl_cs_n, fl_rd_n, fl_wr_n, fl_dq_oe, fl_req}, 5'b11100);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R1: unused bits read zero, other offsets dead
      reg_wr(DATR, 32'hFFFF_FFFF);
      reg_rd(DATR, v); chk(v == 32'h0000_00FF, "R1", "data register unused bits", v, 32'hFF);
      reg_wr(CMD, 32'hFDFF_FFFF);
      reg_rd(CMD, v); chk(v == 32'h0107_FFFF, "R1", "command register unused bits", v, 32'h0107_FFFF);
      reg_wr(8'h58, 32'hFFFF_FFFF);
      reg_rd(8'h58, v); chk(v == 0, "R1", "unmapped offset reads zero", v, 0);
      reg_rd(CMD, v); chk(v == 32'h0107_FFFF, "R1", "unmapped write leaves command", v, 32'h0107_FFFF);

      // R2: writing 0 to bit 25 starts nothing
      reg_wr(CMD, 32'h0100_0123);
      for (int k = 0; k < 5; k++) begin
         @(negedge clk);
         chk(fl_cs_n && !fl_req, "R2", "no cycle without start bit", {fl_cs_n, fl_req}, 2'b10);
      end
      reg_rd(CMD, v); chk(v == 32'h0100_0123, "R2", "fields loaded without start", v, 32'h0100_0123);

      // R2 R5: basic write, busy visible during the access
      reg_wr(DATR, 32'h0000_0077);
      reg_wr(CMD, 32'h0200_0321);
      reg_rd(CMD, v); chk(v == 32'h0200_0321, "R2", "busy bit set during access", v, 32'h0200_0321);
      wait_idle();
      exp_mem[32'h321] = 8'h77;
      chk(fmem.exists(32'h321) && fmem[32'h321] == 8'h77, "R5", "byte landed in flash",
          fmem.exists(32'h321) ? fmem[32'h321] : 8'hxx, 8'h77);
      do_read(32'h321, b); chk(b == 8'h77, "R4", "read back written byte", b, 8'h77);

      // R6: writes during busy ignored
      reg_wr(DATR, 32'h0000_00A5);
      reg_wr(CMD, 32'h0201_2345);
      reg_wr(CMD, 32'h0300_0ABC);
      reg_wr(DATR, 32'h0000_003C);
      wait_idle();
      exp_mem[32'h12345] = 8'hA5;
      reg_rd(CMD, v);  chk(v == 32'h0001_2345, "R6", "command unchanged by busy write", v, 32'h0001_2345);
      reg_rd(DATR, v); chk(v == 32'h0000_00A5, "R6", "data unchanged by busy write", v, 32'hA5);
      chk(fmem.exists(32'h12345) && fmem[32'h12345] == 8'hA5, "R6", "flash got original byte",
          fmem.exists(32'h12345) ? fmem[32'h12345] : 8'hxx, 8'hA5);
      chk(!fmem.exists(32'hABC), "R6", "second start did not write", 0, 0);

      // R3: grant low holds the access off
      fl_gnt = 1'b0;
      reg_wr(CMD, 32'h0300_0456);
      for (int k = 0; k < 8; k++) begin
         @(negedge clk);
         chk(fl_cs_n && fl_req, "R3", "no cycle while grant low", {fl_cs_n, fl_req}, 2'b11);
      end
      fl_gnt = 1'b1;
      wait_idle();
      reg_rd(DATR, v); chk(v[7:0] == init_pat(32'h456), "R3", "read done after grant", v, init_pat(32'h456));

      // R4 R5: boundary addresses
      do_write(32'h7FFFF, 8'h00);
      do_write(32'h00000, 8'hFF);
      do_read(32'h7FFFF, b); chk(b == 8'h00, "R4", "read top address", b, 8'h00);
      do_read(32'h00000, b); chk(b == 8'hFF, "R4", "read address zero", b, 8'hFF);

      // random traffic with random grant
      rand_gnt = 1'b1;
      for (int i = 0; i < 60; i++) begin
         int a;
         a = int'($urandom % 32'h8_0000);
         if (($urandom % 2) == 0) do_write(a, 8'($urandom));
         else begin
            do_read(a, b);
            chk(b == expect_byte(a), "R4", "random read data", b, expect_byte(a));
         end
      end
      rand_gnt = 1'b0;
      fl_gnt = 1'b1;
      repeat (4) @(negedge clk);
      summary();
      $finish;
   end

endmodule